// File: doc/BRIEF.md
# Keyed Memory Self-Test Controller

The block is a built-in self-test controller for one small on-chip RAM, programmed by a host over a flat register port. Nothing inside it leaves reset until the host writes an opening key into a control byte. After that the host turns on the test clock. It then uses an override register to open or close host access to the algorithm and memory-group selections, and a ROM-mask register to choose where those selections come from: the host registers or a small constant table that models the algorithm ROM.

A fixed start code written to the data-logger register launches a March C- pass over the RAM, with one memory operation per enabled cycle. When the pass ends, a level interrupt rises. Fail-status registers then read zero on a pass and hold a mismatch mask and count on a failure. Captured-address registers report whether a pass really ran, the first failing address, and the number of reads. Writing zero to the control byte closes the key, puts the whole controller back in reset and wipes every status register. This is the required step before the controller is reprogrammed.

Top module: `mbist_keyed_ctrl`

## Requirements
- R1: Register addresses are KEY=0x0, CLK=0x1, LOOP0..LOOP3=0x2..0x5, OVR=0x6, DLOG=0x7, ALG=0x8, GRPLO=0x9, GRPHI=0xA, RMSK=0xB, FAIL0=0xC, FAIL1=0xD, CAPA1=0xE, CAPA2=0xF. The controller stays in reset, and every register except KEY reads 0 and ignores writes, unless KEY holds 0xA5 (bits [3:0]=0x5 and bits [7:4]=0xA).
- R2: Writing 0x00 to KEY clears every configuration and status register, and drops the interrupt, within two cycles.
- R3: With the key open, CLK bit 0 can always be written. Every other write, except to KEY, is ignored while CLK bit 0 is 0. A running pass freezes while CLK bit 0 is 0 and resumes without repeating any operation.
- R4: LOOP0..LOOP3 read 0 after reset and after the key is closed, and read back what the host writes.
- R5: ALG, GRPLO and GRPHI accept host writes only while OVR reads 0x9.
- R6: RMSK bit 0 takes the algorithm from the ROM table (value 0x01) instead of ALG. RMSK bit 1 takes the memory group from the ROM table (GRPLO=0x0001, GRPHI=0x0000) instead of GRPLO/GRPHI.
- R7: On a start, when OVR bit 0 is 1, each ROM-selected field is copied into its host register. When OVR is 0x0, the host registers keep their values.
- R8: A DLOG write of 0x021C starts a pass when no pass is running. Any other DLOG value, such as 0x0010, is only stored and starts nothing.
- R9: The interrupt is a level that rises at completion and stays high until KEY is closed or a new start is accepted.
- R10: On a fault-free RAM, a pass ends with FAIL0=0, FAIL1=0, CAPA1=0x0100 (bit 8 means a pass ran) and CAPA2=0x0050 (80 reads).
- R11: On a failing RAM, FAIL0 holds the XOR of read and expected data at the first mismatch, FAIL1 holds the saturating mismatch count, and CAPA1 bits [3:0] hold the first failing address.
- R12: A start whose selected algorithm is not 0x01, or whose group is not GRPLO=0x0001 with GRPHI=0x0000, runs no memory operation. It still raises the interrupt, and CAPA1 and CAPA2 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_done | output | 1 | Level completion interrupt |

## Verification
The bench builds two copies of the block. One has the default fault-free parameters. The other has FAULT_EN=1, FAULT_ADDR=5 and FAULT_BIT=2, which holds bit 2 of word 5 at 1. The faulty copy makes the failure path reachable: the first mismatch comes in the first ascending read-zero element at address 5, giving FAIL0=0x04. Three read-zero elements miss, so FAIL1=3 and CAPA1=0x0105. The fault-free copy checks the pass signature, the key and override gating, ROM selection with and without copy-back, and a pass frozen mid-run by clearing the clock bit.

// File: rtl/mbk_pkg.sv
package mbk_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] RA_KEY  = 4'h0;
  localparam logic [REG_AW-1:0] RA_CLK  = 4'h1;
  localparam logic [REG_AW-1:0] RA_LP0  = 4'h2;
  localparam logic [REG_AW-1:0] RA_OVR  = 4'h6;
  localparam logic [REG_AW-1:0] RA_DLOG = 4'h7;
  localparam logic [REG_AW-1:0] RA_ALG  = 4'h8;
  localparam logic [REG_AW-1:0] RA_GLO  = 4'h9;
  localparam logic [REG_AW-1:0] RA_GHI  = 4'hA;
  localparam logic [REG_AW-1:0] RA_RMSK = 4'hB;
  localparam logic [REG_AW-1:0] RA_FL0  = 4'hC;
  localparam logic [REG_AW-1:0] RA_FL1  = 4'hD;
  localparam logic [REG_AW-1:0] RA_CA1  = 4'hE;
  localparam logic [REG_AW-1:0] RA_CA2  = 4'hF;

  localparam int N_LOOP = 4;

  localparam logic [7:0]        KEY_OPEN = 8'hA5;
  localparam logic [3:0]        OVR_HOST = 4'h9;
  localparam logic [REG_DW-1:0] DLOG_GO  = 16'h021C;
  localparam logic [7:0]        ALG_MARCH = 8'h01;

  // constant selection table: [0] algorithm, [1] group low, [2] group high
  localparam int ROM_N = 3;
  localparam logic [ROM_N-1:0][REG_DW-1:0] ROM_TBL = {16'h0000, 16'h0001, 16'h0001};

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} eng_st_e;

  localparam int N_ELEM = 6;
endpackage

// File: rtl/mbk_ram.sv
module mbk_ram #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter bit FAULT_EN   = 1'b0,
  parameter int FAULT_ADDR = 0,
  parameter int FAULT_BIT  = 0
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] raw;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign raw = mem[addr];

  generate
    if (FAULT_EN) begin : g_stuck
      localparam logic [ADDR_W-1:0] F_ADDR = ADDR_W'(FAULT_ADDR);
      localparam logic [DATA_W-1:0] F_MASK = DATA_W'(1) << FAULT_BIT;
      assign rdata = (addr == F_ADDR) ? (raw | F_MASK) : raw;
    end else begin : g_clean
      assign rdata = raw;
    end
  endgenerate
endmodule

// File: rtl/mbk_regs.sv
module mbk_regs
  import mbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              busy,
  output logic              key_ok,
  output logic              clk_act,
  output logic              start_go,
  output logic              run_ok,
  output logic [7:0]        key_o,
  output logic [N_LOOP-1:0][REG_DW-1:0] loop_o,
  output logic [3:0]        ovr_o,
  output logic [REG_DW-1:0] dlog_o,
  output logic [7:0]        alg_o,
  output logic [REG_DW-1:0] glo_o,
  output logic [REG_DW-1:0] ghi_o,
  output logic [1:0]        rmsk_o
);
  localparam logic [7:0]        ROM_ALG = ROM_TBL[0][7:0];
  localparam logic [REG_DW-1:0] ROM_GLO = ROM_TBL[1];
  localparam logic [REG_DW-1:0] ROM_GHI = ROM_TBL[2];

  logic [7:0]        key_q, key_d;
  logic              clk_q, clk_d;
  logic [N_LOOP-1:0][REG_DW-1:0] loop_q, loop_d;
  logic [3:0]        ovr_q, ovr_d;
  logic [REG_DW-1:0] dlog_q, dlog_d;
  logic [7:0]        alg_q, alg_d;
  logic [REG_DW-1:0] glo_q, glo_d, ghi_q, ghi_d;
  logic [1:0]        rmsk_q, rmsk_d;

  logic wr_open, wr_cfg, host_sel, copy_back;
  logic [7:0]        eff_alg;
  logic [REG_DW-1:0] eff_glo, eff_ghi;

  assign key_ok    = (key_q == KEY_OPEN);
  assign wr_open   = we && key_ok;
  assign wr_cfg    = wr_open && clk_q;
  assign host_sel  = (ovr_q == OVR_HOST);
  assign start_go  = wr_cfg && (addr == RA_DLOG) && (wdata == DLOG_GO) && !busy;
  assign copy_back = start_go && ovr_q[0];

  assign eff_alg = rmsk_q[0] ? ROM_ALG : alg_q;
  assign eff_glo = rmsk_q[1] ? ROM_GLO : glo_q;
  assign eff_ghi = rmsk_q[1] ? ROM_GHI : ghi_q;
  assign run_ok  = (eff_alg == ALG_MARCH) && (eff_glo == 16'h0001) && (eff_ghi == '0);

  always_comb begin
    key_d  = key_q;
    clk_d  = clk_q;
    loop_d = loop_q;
    ovr_d  = ovr_q;
    dlog_d = dlog_q;
    alg_d  = alg_q;
    glo_d  = glo_q;
    ghi_d  = ghi_q;
    rmsk_d = rmsk_q;
    if (we && addr == RA_KEY) key_d = wdata[7:0];
    if (!key_ok) begin
      clk_d  = 1'b0;
      loop_d = '0;
      ovr_d  = '0;
      dlog_d = '0;
      alg_d  = '0;
      glo_d  = '0;
      ghi_d  = '0;
      rmsk_d = '0;
    end else begin
      if (wr_open && addr == RA_CLK) clk_d = wdata[0];
      if (wr_cfg) begin
        for (int i = 0; i < N_LOOP; i++) begin
          if (addr == RA_LP0 + REG_AW'(i)) loop_d[i] = wdata;
        end
        if (addr == RA_OVR)  ovr_d  = wdata[3:0];
        if (addr == RA_DLOG) dlog_d = wdata;
        if (addr == RA_RMSK) rmsk_d = wdata[1:0];
        if (host_sel && addr == RA_ALG) alg_d = wdata[7:0];
        if (host_sel && addr == RA_GLO) glo_d = wdata;
        if (host_sel && addr == RA_GHI) ghi_d = wdata;
      end
      if (copy_back && rmsk_q[0]) alg_d = ROM_ALG;
      if (copy_back && rmsk_q[1]) begin
        glo_d = ROM_GLO;
        ghi_d = ROM_GHI;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      clk_q  <= 1'b0;
      loop_q <= '0;
      ovr_q  <= '0;
      dlog_q <= '0;
      alg_q  <= '0;
      glo_q  <= '0;
      ghi_q  <= '0;
      rmsk_q <= '0;
    end else begin
      key_q  <= key_d;
      clk_q  <= clk_d;
      loop_q <= loop_d;
      ovr_q  <= ovr_d;
      dlog_q <= dlog_d;
      alg_q  <= alg_d;
      glo_q  <= glo_d;
      ghi_q  <= ghi_d;
      rmsk_q <= rmsk_d;
    end
  end

  assign clk_act = clk_q;
  assign key_o   = key_q;
  assign loop_o  = loop_q;
  assign ovr_o   = ovr_q;
  assign dlog_o  = dlog_q;
  assign alg_o   = alg_q;
  assign glo_o   = glo_q;
  assign ghi_o   = ghi_q;
  assign rmsk_o  = rmsk_q;

  // R1
  key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_ok && $past(!key_ok)) |-> (dlog_q == '0 && clk_q == 1'b0));

  // R3
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && $past(key_ok) && !$past(clk_q)) |-> (ovr_q == $past(ovr_q) && rmsk_q == $past(rmsk_q)));

  // R5
  ovr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && $past(key_ok) && $past(ovr_q) == 4'h0) |-> (alg_q == $past(alg_q) && glo_q == $past(glo_q)));
endmodule

// File: rtl/mbk_march.sv
module mbk_march
  import mbk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_ok,
  input  logic              clk_en,
  input  logic              start_go,
  input  logic              run_ok,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              busy,
  output logic              irq,
  output logic [REG_DW-1:0] fail0,
  output logic [REG_DW-1:0] fail1,
  output logic [REG_DW-1:0] capa1,
  output logic [REG_DW-1:0] capa2
);
  localparam logic [ADDR_W-1:0] IDX_MAX   = '1;
  localparam logic [2:0]        LAST_ELEM = 3'(N_ELEM - 1);
  localparam int                CNT_W     = 8;

  eng_st_e            st_q, st_d;
  logic [2:0]         elem_q, elem_d;
  logic [ADDR_W-1:0]  idx_q, idx_d;
  logic               irq_q, irq_d;
  logic               ran_q, ran_d;
  logic [DATA_W-1:0]  fmask_q, fmask_d;
  logic [CNT_W-1:0]   fcnt_q, fcnt_d;
  logic [ADDR_W-1:0]  ffirst_q, ffirst_d;
  logic [REG_DW-1:0]  rdcnt_q, rdcnt_d;

  logic step, op_rd, op_wr, exp_one, wr_one, go_down, miss;
  logic [DATA_W-1:0] exp_word;

  // March C-: w0 / up r0w1 / up r1w0 / down r0w1 / down r1w0 / r0
  assign step      = (st_q == ST_RUN) && clk_en;
  assign op_rd     = (elem_q != 3'd0);
  assign op_wr     = (elem_q != LAST_ELEM);
  assign exp_one   = (elem_q == 3'd2) || (elem_q == 3'd4);
  assign wr_one    = (elem_q == 3'd1) || (elem_q == 3'd3);
  assign go_down   = (elem_q == 3'd3) || (elem_q == 3'd4);
  assign exp_word  = exp_one ? '1 : '0;
  assign ram_addr  = go_down ? ~idx_q : idx_q;
  assign ram_wdata = wr_one ? '1 : '0;
  assign ram_we    = step && op_wr;
  assign miss      = step && op_rd && (ram_rdata != exp_word);

  always_comb begin
    st_d     = st_q;
    elem_d   = elem_q;
    idx_d    = idx_q;
    irq_d    = irq_q;
    ran_d    = ran_q;
    fmask_d  = fmask_q;
    fcnt_d   = fcnt_q;
    ffirst_d = ffirst_q;
    rdcnt_d  = rdcnt_q;
    if (!key_ok) begin
      st_d     = ST_IDLE;
      elem_d   = '0;
      idx_d    = '0;
      irq_d    = 1'b0;
      ran_d    = 1'b0;
      fmask_d  = '0;
      fcnt_d   = '0;
      ffirst_d = '0;
      rdcnt_d  = '0;
    end else if (start_go) begin
      elem_d   = '0;
      idx_d    = '0;
      fmask_d  = '0;
      fcnt_d   = '0;
      ffirst_d = '0;
      rdcnt_d  = '0;
      ran_d    = run_ok;
      st_d     = run_ok ? ST_RUN : ST_DONE;
      irq_d    = !run_ok;
    end else if (step) begin
      if (op_rd) rdcnt_d = rdcnt_q + 1'b1;
      if (miss) begin
        if (fcnt_q == '0) begin
          fmask_d  = ram_rdata ^ exp_word;
          ffirst_d = ram_addr;
        end
        if (fcnt_q != '1) fcnt_d = fcnt_q + 1'b1;
      end
      if (idx_q == IDX_MAX) begin
        idx_d = '0;
        if (elem_q == LAST_ELEM) begin
          st_d  = ST_DONE;
          irq_d = 1'b1;
        end else begin
          elem_d = elem_q + 1'b1;
        end
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      elem_q   <= '0;
      idx_q    <= '0;
      irq_q    <= 1'b0;
      ran_q    <= 1'b0;
      fmask_q  <= '0;
      fcnt_q   <= '0;
      ffirst_q <= '0;
      rdcnt_q  <= '0;
    end else begin
      st_q     <= st_d;
      elem_q   <= elem_d;
      idx_q    <= idx_d;
      irq_q    <= irq_d;
      ran_q    <= ran_d;
      fmask_q  <= fmask_d;
      fcnt_q   <= fcnt_d;
      ffirst_q <= ffirst_d;
      rdcnt_q  <= rdcnt_d;
    end
  end

  assign busy  = (st_q == ST_RUN);
  assign irq   = irq_q;
  assign fail0 = REG_DW'(fmask_q);
  assign fail1 = REG_DW'(fcnt_q);
  assign capa1 = (REG_DW'(ran_q) << 8) | REG_DW'(ffirst_q);
  assign capa2 = rdcnt_q;

  // R8
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN && !start_go) |=> (st_q != ST_RUN));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && key_ok && !start_go) |=> irq_q);

  // R11
  fcnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_ok && !start_go) |=> (fcnt_q >= $past(fcnt_q)));

  // R3
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clk_en && key_ok && !start_go) |=> ($stable(idx_q) && $stable(rdcnt_q)));
endmodule

// File: rtl/mbist_keyed_ctrl.sv
module mbist_keyed_ctrl
  import mbk_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter bit FAULT_EN   = 1'b0,
  parameter int FAULT_ADDR = 0,
  parameter int FAULT_BIT  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_done
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic key_ok, clk_act, start_go, run_ok, busy;
  logic [7:0]        key_v, alg_v;
  logic [N_LOOP-1:0][REG_DW-1:0] loop_v;
  logic [3:0]        ovr_v;
  logic [1:0]        rmsk_v;
  logic [REG_DW-1:0] dlog_v, glo_v, ghi_v, fl0_v, fl1_v, ca1_v, ca2_v;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  mbk_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .key_ok   (key_ok),
    .clk_act  (clk_act),
    .start_go (start_go),
    .run_ok   (run_ok),
    .key_o    (key_v),
    .loop_o   (loop_v),
    .ovr_o    (ovr_v),
    .dlog_o   (dlog_v),
    .alg_o    (alg_v),
    .glo_o    (glo_v),
    .ghi_o    (ghi_v),
    .rmsk_o   (rmsk_v)
  );

  mbk_march #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_march (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .key_ok    (key_ok),
    .clk_en    (clk_act),
    .start_go  (start_go),
    .run_ok    (run_ok),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .busy      (busy),
    .irq       (irq_done),
    .fail0     (fl0_v),
    .fail1     (fl1_v),
    .capa1     (ca1_v),
    .capa2     (ca2_v)
  );

  mbk_ram #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FAULT_EN(FAULT_EN), .FAULT_ADDR(FAULT_ADDR), .FAULT_BIT(FAULT_BIT)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_KEY:  reg_rdata = {8'h00, key_v};
      RA_CLK:  reg_rdata = {15'h0, clk_act};
      RA_OVR:  reg_rdata = {12'h0, ovr_v};
      RA_DLOG: reg_rdata = dlog_v;
      RA_ALG:  reg_rdata = {8'h00, alg_v};
      RA_GLO:  reg_rdata = glo_v;
      RA_GHI:  reg_rdata = ghi_v;
      RA_RMSK: reg_rdata = {14'h0, rmsk_v};
      RA_FL0:  reg_rdata = fl0_v;
      RA_FL1:  reg_rdata = fl1_v;
      RA_CA1:  reg_rdata = ca1_v;
      RA_CA2:  reg_rdata = ca2_v;
      default: reg_rdata = loop_v[reg_addr - RA_LP0];
    endcase
  end
endmodule

// File: tb/test_mbist_keyed_ctrl.sv
`timescale 1ns/1ps
module test_mbist_keyed_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] rdata_a, rdata_f;
  logic        irq_a, irq_f;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbist_keyed_ctrl i_mbist_keyed_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq_done(irq_a)
  );

  mbist_keyed_ctrl #(.FAULT_EN(1'b1), .FAULT_ADDR(5), .FAULT_BIT(2)) i_mbist_keyed_ctrl_flt (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_f), .irq_done(irq_f)
  );

  // vector: {req[3:0], wr, addr[3:0], data[15:0], exp[15:0]}
  localparam int NV = 31;
  localparam logic [NV-1:0][40:0] VEC = {
    {4'd8, 1'b0, 4'hD, 16'h0000, 16'h0000},  // 30 R8 no fail count
    {4'd8, 1'b0, 4'hF, 16'h0000, 16'h0000},  // 29 R8 0x10 did not run
    {4'd5, 1'b0, 4'h8, 16'h0000, 16'h0002},  // 28 R5 ALG kept with OVR=0
    {4'd5, 1'b1, 4'h8, 16'h0001, 16'h0000},  // 27
    {4'd5, 1'b1, 4'h6, 16'h0000, 16'h0000},  // 26 OVR=0
    {4'd5, 1'b0, 4'h9, 16'h0000, 16'h0001},  // 25 R5
    {4'd5, 1'b1, 4'h9, 16'h0001, 16'h0000},  // 24
    {4'd5, 1'b0, 4'h8, 16'h0000, 16'h0002},  // 23 R5
    {4'd5, 1'b1, 4'h8, 16'h0002, 16'h0000},  // 22
    {4'd8, 1'b0, 4'h7, 16'h0000, 16'h0010},  // 21 R8
    {4'd8, 1'b1, 4'h7, 16'h0010, 16'h0000},  // 20
    {4'd5, 1'b0, 4'h6, 16'h0000, 16'h0009},  // 19 R5
    {4'd5, 1'b1, 4'h6, 16'h0009, 16'h0000},  // 18
    {4'd5, 1'b0, 4'h8, 16'h0000, 16'h0000},  // 17 R5 ALG locked
    {4'd5, 1'b1, 4'h8, 16'h0001, 16'h0000},  // 16
    {4'd4, 1'b0, 4'h4, 16'h0000, 16'h0033},  // 15 R4
    {4'd4, 1'b1, 4'h4, 16'h0033, 16'h0000},  // 14
    {4'd4, 1'b0, 4'h5, 16'h0000, 16'h0000},  // 13 R4
    {4'd4, 1'b0, 4'h2, 16'h0000, 16'h0000},  // 12 R4
    {4'd3, 1'b0, 4'h1, 16'h0000, 16'h0001},  // 11 R3
    {4'd3, 1'b1, 4'h1, 16'h0001, 16'h0000},  // 10
    {4'd3, 1'b0, 4'h6, 16'h0000, 16'h0000},  // 9  R3 OVR ignored, clock off
    {4'd3, 1'b1, 4'h6, 16'h0009, 16'h0000},  // 8
    {4'd1, 1'b0, 4'h0, 16'h0000, 16'h00A5},  // 7  R1
    {4'd1, 1'b1, 4'h0, 16'h00A5, 16'h0000},  // 6
    {4'd1, 1'b0, 4'h1, 16'h0000, 16'h0000},  // 5  R1 half key
    {4'd1, 1'b1, 4'h1, 16'h0001, 16'h0000},  // 4
    {4'd1, 1'b1, 4'h0, 16'h0005, 16'h0000},  // 3
    {4'd1, 1'b0, 4'h1, 16'h0000, 16'h0000},  // 2  R1 locked
    {4'd1, 1'b1, 4'h1, 16'h0001, 16'h0000},  // 1
    {4'd1, 1'b0, 4'h0, 16'h0000, 16'h0000}   // 0  R1 reset value
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d, output logic [15:0] df);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1;
    d = rdata_a; df = rdata_f;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] e, input string req);
    logic [15:0] d, df;
    rd(a, d, df);
    chk(d == e, req, d, e);
  endtask

  task automatic rd_chk_f(input logic [3:0] a, input logic [15:0] e, input string req);
    logic [15:0] d, df;
    rd(a, d, df);
    chk(df == e, req, df, e);
  endtask

  task automatic wait_irq(input string req);
    bit got = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq_a) begin got = 1'b1; break; end
    end
    chk(got, req, irq_a, 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk(irq_a == 1'b0, "R9 reset", irq_a, 0);

    for (int v = 0; v < NV; v++) begin
      logic [40:0] e;
      e = VEC[v];
      if (e[36]) wr(e[35:32], e[31:16]);
      else begin
        logic [15:0] d, df;
        rd(e[35:32], d, df);
        chk(d == e[15:0], $sformatf("R%0d vec%0d", e[40:37], v), d, e[15:0]);
      end
    end

    // R12: host algorithm 0x02 is not the march, no ROM selection
    rd_chk(4'hB, 16'h0000, "R12 rmsk");
    wr(4'h7, 16'h021C);
    wait_irq("R12 irq");
    rd_chk(4'hE, 16'h0000, "R12 capa1");
    rd_chk(4'hF, 16'h0000, "R12 capa2");

    // R9: level holds
    idle(20);
    chk(irq_a == 1'b1, "R9 hold", irq_a, 1);

    // R6 algorithm from ROM, OVR=0 so no copy-back (R7)
    wr(4'hB, 16'h0001);
    wr(4'h7, 16'h021C);
    chk(irq_a == 1'b0, "R9 cleared by start", irq_a, 0);
    wait_irq("R6 irq");
    chk(irq_f == 1'b1, "R11 irq", irq_f, 1);
    rd_chk(4'hC, 16'h0000, "R10 fail0");
    rd_chk(4'hD, 16'h0000, "R10 fail1");
    rd_chk(4'hE, 16'h0100, "R10 capa1");
    rd_chk(4'hF, 16'h0050, "R10 capa2");
    rd_chk_f(4'hC, 16'h0004, "R11 fail0");
    rd_chk_f(4'hD, 16'h0003, "R11 fail1");
    rd_chk_f(4'hE, 16'h0105, "R11 capa1");
    rd_chk_f(4'hF, 16'h0050, "R11 capa2");
    rd_chk(4'h8, 16'h0002, "R7 no copy-back");

    // R7 copy-back with OVR=0x9, R6 group from ROM
    wr(4'h6, 16'h0009);
    wr(4'h8, 16'h0004);
    wr(4'h9, 16'h0000);
    wr(4'hB, 16'h0003);
    wr(4'h7, 16'h021C);
    rd_chk(4'h8, 16'h0001, "R7 alg copied");
    rd_chk(4'h9, 16'h0001, "R7 group copied");
    wait_irq("R6 irq group");
    rd_chk(4'hF, 16'h0050, "R6 group from ROM");

    // R3 pause mid-run
    wr(4'h7, 16'h021C);
    idle(10);
    wr(4'h1, 16'h0000);
    idle(200);
    chk(irq_a == 1'b0, "R3 frozen", irq_a, 0);
    wr(4'hB, 16'h0000);
    rd_chk(4'hB, 16'h0003, "R3 write ignored");
    wr(4'h1, 16'h0001);
    wait_irq("R3 resume");
    rd_chk(4'hF, 16'h0050, "R3 no repeat");

    // R2 close key
    wr(4'h0, 16'h0000);
    idle(2);
    chk(irq_a == 1'b0, "R2 irq", irq_a, 0);
    rd_chk(4'hF, 16'h0000, "R2 capa2");
    rd_chk(4'h8, 16'h0000, "R2 alg");
    rd_chk(4'h4, 16'h0000, "R4 loop cleared");
    rd_chk_f(4'hC, 16'h0000, "R2 fail0");
    wr(4'h0, 16'h00A5);
    rd_chk(4'h1, 16'h0000, "R2 clk");

    // R8 wrong start code
    wr(4'h1, 16'h0001);
    wr(4'hB, 16'h0003);
    wr(4'h7, 16'h021D);
    idle(150);
    chk(irq_a == 1'b0, "R8 no start", irq_a, 0);
    rd_chk(4'hF, 16'h0000, "R8 capa2");
    wr(4'h7, 16'h021C);
    wait_irq("R8 start");
    rd_chk(4'hE, 16'h0100, "R8 capa1");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule